// File: doc/BRIEF.md
# Active Video Start Delay Timer

This block finds where the active pixels begin on each video line. A reference event restarts a line. The reference is either the rising edge of horizontal sync or the rising edge of a data-start strobe, chosen by a configuration input. The block then counts a programmed number of whole pixels. When the count completes, it emits a one-clock start flag and raises an active-region level, and that level gates the capture of incoming pixel data.

The logic runs at the input clock. One pixel lasts one, two or three of those clocks, chosen by a clock-mode input, so the distance from the reference to the first active data is always a whole number of pixels. The 9-bit delay is written through a small register port. One register holds the low eight bits. A second register, the overflow register, holds delay bit 8 in its bit 2, and two further position bits that the block keeps for software. Captured data is taken on the rising or the falling clock edge, chosen by a select bit. In a data-start setup the delay is normally programmed to 11 pixels.

Top module: `avs_timer`

## Requirements
- R1: After synchronous reset, both registers read back 0, and `sav_pulse` and `active` are low.
- R2: The delay D is the 9-bit value {overflow register bit 2, low register[7:0]}. Register 0 is selected by `wr_sel`/`rd_sel` = 0 and register 1 (overflow) by 1. `sav_pulse` rises (D+1)*N clocks after the clock edge that samples the reference edge.
- R3: `clk_mode` sets N, the input clocks per pixel: 0 gives 1, 1 gives 2, 2 gives 3, and 3 gives 1. The reference-to-start distance is therefore always a multiple of N clocks.
- R4: With `ref_sel`=0 the reference is a rising `hsync`. With `ref_sel`=1 it is a rising `dstart`. The unselected input has no effect.
- R5: `sav_pulse` lasts exactly one clock. `active` rises with it and stays high until the next reference edge, which clears it.
- R6: A reference edge that arrives during a count restarts the count from zero.
- R7: Register writes and `clk_mode` changes apply from the next reference edge. A line already being counted keeps its timing.
- R8: Bits 1 and 0 of the overflow register are stored and read back, and they have no effect on timing.
- R9: `pix_out` changes only while `active` is high. Otherwise it holds its value.
- R10: With `latch_pos`=1, `pix_out` shows data taken at the rising clock edge. With 0, it shows data taken at the falling edge.
- R11: A delay of 0 starts active video at the first pixel boundary after the reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (1x, 2x or 3x pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 low delay byte, 1 overflow register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target, same encoding as `wr_sel` |
| rd_data | output | 8 | Read data |
| clk_mode | input | 2 | Clocks per pixel select |
| ref_sel | input | 1 | Reference select: 0 sync, 1 data-start |
| latch_pos | input | 1 | Capture edge: 1 rising, 0 falling |
| hsync | input | 1 | Horizontal sync, leading edge is rising |
| dstart | input | 1 | Data-start strobe |
| pix_in | input | 8 | Incoming pixel data |
| sav_pulse | output | 1 | One-clock start-of-active-video flag |
| active | output | 1 | Active-region level |
| pix_out | output | 8 | Captured pixel data |

## Verification
The hardest state to reach from the ports is a count that is in progress when the configuration or the reference changes. To get there, the stimulus raises the reference, waits a few clocks, and then either rewrites the delay or drops the reference and raises it again. It then measures the clocks from the reference to the start flag against the old and the new settings. The falling-edge capture path is reached by changing `pix_in` between a falling and a rising edge while `active` is high, and then comparing both edge selections.

// File: rtl/avs_pkg.sv
package avs_pkg;
    localparam int DLY_W  = 9;
    localparam int REG_W  = 8;
    localparam int DATA_W = 8;
    localparam int PH_W   = 2;

    typedef enum logic [1:0] {
        MODE_1X  = 2'd0,
        MODE_2X  = 2'd1,
        MODE_3X  = 2'd2,
        MODE_RSV = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [PH_W-1:0]  div;
    } line_cfg_t;

    function automatic logic [PH_W-1:0] clocks_per_pixel(input clk_mode_e m);
        case (m)
            MODE_2X: return 2'd2;
            MODE_3X: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/avs_regs.sv
module avs_regs
    import avs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [DLY_W-1:0] dly_live
);
    logic [REG_W-1:0] dly_lo;
    logic [2:0]       ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_lo <= '0;
            ovf    <= '0;
        end else if (wr_en) begin
            if (wr_sel) ovf    <= wr_data[2:0];
            else        dly_lo <= wr_data;
        end
    end

    always_comb begin
        rd_data  = rd_sel ? {{(REG_W-3){1'b0}}, ovf} : dly_lo;
        dly_live = {ovf[2], dly_lo};
    end
endmodule

// File: rtl/avs_edge.sv
module avs_edge (
    input  logic clk,
    input  logic rst,
    input  logic ref_sel,
    input  logic hsync,
    input  logic dstart,
    output logic ref_edge
);
    logic hs_q, ds_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            ds_q <= 1'b0;
        end else begin
            hs_q <= hsync;
            ds_q <= dstart;
        end
    end

    always_comb ref_edge = ref_sel ? (dstart & ~ds_q) : (hsync & ~hs_q);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ref_edge |=> !ref_edge); // R4
endmodule

// File: rtl/avs_counter.sv
module avs_counter
    import avs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic [DLY_W-1:0] dly_live,
    input  clk_mode_e        mode,
    output logic             sav_pulse,
    output logic             active
);
    line_cfg_t        cfg_s;
    logic [PH_W-1:0]  phase;
    logic [DLY_W-1:0] pix_cnt;
    logic             counting;
    logic             boundary;

    always_comb boundary = counting && (phase == cfg_s.div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_s     <= '{dly: '0, div: 2'd1};
            phase     <= '0;
            pix_cnt   <= '0;
            counting  <= 1'b0;
            sav_pulse <= 1'b0;
            active    <= 1'b0;
        end else begin
            sav_pulse <= 1'b0;
            if (ref_edge) begin
                cfg_s    <= '{dly: dly_live, div: clocks_per_pixel(mode)};
                phase    <= '0;
                pix_cnt  <= '0;
                counting <= 1'b1;
                active   <= 1'b0;
            end else if (counting) begin
                if (boundary) begin
                    phase <= '0;
                    if (pix_cnt == cfg_s.dly) begin
                        sav_pulse <= 1'b1;
                        active    <= 1'b1;
                        counting  <= 1'b0;
                    end else begin
                        pix_cnt <= pix_cnt + 1'b1;
                    end
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    AST_SAV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sav_pulse |=> !sav_pulse); // R5
    AST_SAV_WITH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        sav_pulse |-> active); // R5
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !ref_edge) |=> active); // R5
    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        ref_edge |=> (!active && !sav_pulse)); // R6
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        counting |-> (phase < cfg_s.div)); // R3
endmodule

// File: rtl/avs_capture.sv
module avs_capture
    import avs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              latch_pos,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out
);
    logic [DATA_W-1:0] cap_p, cap_n;

    always_ff @(posedge clk) begin
        if (rst)     cap_p <= '0;
        else if (en) cap_p <= pix_in;
    end

    always_ff @(negedge clk) begin
        if (rst)     cap_n <= '0;
        else if (en) cap_n <= pix_in;
    end

    always_comb pix_out = latch_pos ? cap_p : cap_n;

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cap_p)); // R9
endmodule

// File: rtl/avs_timer.sv
module avs_timer
    import avs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic [1:0]        clk_mode,
    input  logic              ref_sel,
    input  logic              latch_pos,
    input  logic              hsync,
    input  logic              dstart,
    input  logic [DATA_W-1:0] pix_in,
    output logic              sav_pulse,
    output logic              active,
    output logic [DATA_W-1:0] pix_out
);
    logic [DLY_W-1:0] dly_live;
    logic             ref_edge;

    avs_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .dly_live(dly_live)
    );

    avs_edge u_edge (
        .clk(clk), .rst(rst), .ref_sel(ref_sel), .hsync(hsync),
        .dstart(dstart), .ref_edge(ref_edge)
    );

    avs_counter u_cnt (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .dly_live(dly_live),
        .mode(clk_mode_e'(clk_mode)), .sav_pulse(sav_pulse), .active(active)
    );

    avs_capture u_cap (
        .clk(clk), .rst(rst), .en(active), .latch_pos(latch_pos),
        .pix_in(pix_in), .pix_out(pix_out)
    );
endmodule

// File: tb/tb_avs_timer.sv
`timescale 1ns/1ps
module tb_avs_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] clk_mode = '0;
    logic       ref_sel = 1'b0, latch_pos = 1'b1;
    logic       hsync = 1'b0, dstart = 1'b0;
    logic [7:0] pix_in = '0;
    logic       sav_pulse, active;
    logic [7:0] pix_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    avs_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_mode(clk_mode), .ref_sel(ref_sel),
        .latch_pos(latch_pos), .hsync(hsync), .dstart(dstart), .pix_in(pix_in),
        .sav_pulse(sav_pulse), .active(active), .pix_out(pix_out)
    );

    // {ref_sel, clk_mode[1:0], delay[8:0]}
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 2'd0, 9'd0},   {1'b0, 2'd1, 9'd5},   {1'b0, 2'd2, 9'd7},
        {1'b1, 2'd0, 9'd11},  {1'b1, 2'd1, 9'd11},  {1'b1, 2'd2, 9'd256},
        {1'b0, 2'd3, 9'd3},   {1'b0, 2'd0, 9'd300}, {1'b1, 2'd2, 9'd511}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_delay(input int d, input logic [1:0] extra);
        wr(1'b0, d[7:0]);
        wr(1'b1, {5'd0, d[8], extra});
    endtask

    task automatic drop_refs();
        hsync = 1'b0; dstart = 1'b0;
        tick();
    endtask

    task automatic raise_ref();
        if (ref_sel) dstart = 1'b1; else hsync = 1'b1;
    endtask

    // clocks from the raising drive to the first cycle sav_pulse is seen
    task automatic wait_sav(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            tick();
            n++;
            if (sav_pulse) return;
        end
        n = -1;
    endtask

    function automatic int npix(input logic [1:0] m);
        return (m == 2'd1) ? 2 : (m == 2'd2) ? 3 : 1;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int exp;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        rd_sel = 1'b0; #1 chk("R1 low reg", rd_data, 0);
        rd_sel = 1'b1; #1 chk("R1 ovf reg", rd_data, 0);
        chk("R1 sav", sav_pulse, 0);
        chk("R1 active", active, 0);

        // Vector walk: R2 R3 R4 R5 R11
        for (int v = 0; v < NV; v++) begin
            drop_refs();
            ref_sel  = VEC[v][11];
            clk_mode = VEC[v][10:9];
            set_delay(int'(VEC[v][8:0]), 2'b00);
            raise_ref();
            exp = (int'(VEC[v][8:0]) + 1) * npix(VEC[v][10:9]) + 1;
            wait_sav(3000, n);
            chk($sformatf("R2/R3 vec%0d start delay", v), n, exp);
            chk("R5 active with sav", active, 1);
            tick();
            chk("R5 sav one cycle", sav_pulse, 0);
            chk("R5 active held", active, 1);
        end

        // R11 delay zero in 3x mode: first pixel boundary
        drop_refs(); ref_sel = 1'b0; clk_mode = 2'd2; set_delay(0, 2'b00);
        raise_ref(); wait_sav(100, n);
        chk("R11 zero delay 3x", n, 4);

        // R4 unselected input ignored: with dstart selected, hsync pulses do nothing
        drop_refs(); ref_sel = 1'b1; clk_mode = 2'd0; set_delay(2, 2'b00);
        raise_ref(); wait_sav(100, n);
        chk("R4 dstart ref", n, 4);
        for (int i = 0; i < 4; i++) begin
            hsync = 1'b1; tick(); hsync = 1'b0; tick();
            chk("R4 hsync ignored sav", sav_pulse, 0);
            chk("R4 hsync ignored active", active, 1);
        end

        // R5 next reference edge clears active
        dstart = 1'b0; tick(); dstart = 1'b1; tick();
        chk("R5 edge clears active", active, 0);

        // R6 restart mid-count
        drop_refs(); ref_sel = 1'b0; clk_mode = 2'd0; set_delay(10, 2'b00);
        raise_ref();
        repeat (5) tick();
        chk("R6 no early sav", active, 0);
        hsync = 1'b0; tick(); hsync = 1'b1;
        wait_sav(100, n);
        chk("R6 restart delay", n, 12);

        // R7 write during a line does not retime it
        drop_refs(); clk_mode = 2'd1; set_delay(3, 2'b00);
        raise_ref(); tick();
        wr(1'b0, 8'd20); clk_mode = 2'd0;
        wait_sav(100, n);
        chk("R7 old timing kept", n + 2, 9);
        drop_refs(); raise_ref(); wait_sav(100, n);
        chk("R7 new timing next line", n, 22);

        // R8 position bits stored, no effect on timing
        drop_refs(); set_delay(4, 2'b11);
        rd_sel = 1'b1; #1 chk("R8 ovf readback", rd_data, 3);
        rd_sel = 1'b0; #1 chk("R8 low readback", rd_data, 4);
        raise_ref(); wait_sav(100, n);
        chk("R8 timing unaffected", n, 6);

        // R10 edge select while active
        pix_in = 8'hA5;
        @(negedge clk); #1 pix_in = 8'h3C;
        @(posedge clk); #1;
        latch_pos = 1'b0; #1 chk("R10 falling edge data", pix_out, 8'hA5);
        latch_pos = 1'b1; #1 chk("R10 rising edge data", pix_out, 8'h3C);

        // R9 capture frozen while inactive
        hsync = 1'b0; tick(); hsync = 1'b1; tick();
        pix_in = 8'h77; tick(); tick();
        chk("R9 frozen rising", pix_out, 8'h3C);
        latch_pos = 1'b0; #1 chk("R9 frozen falling", pix_out, 8'h3C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule